// File: doc/BRIEF.md
# Masked Three-Input Bitwise Logic Unit

This unit combines three 512-bit operand vectors bit by bit under any of the 256 Boolean functions of three inputs. An 8-bit function code holds the whole truth table of that function. The raw result is then masked per element. The vector is viewed either as sixteen 32-bit elements or as eight 64-bit elements. A mask word chooses, for each element, whether that element takes the computed value. An element that is not selected is cleared or keeps the value of a fourth pass-through vector, according to a mode bit.

Operands enter through a valid/ready handshake together with the code, the mask, the width select and the mode. The result is held in an output register and leaves through a second valid/ready handshake. A new operation can be accepted in every cycle in which the output register is empty or is being drained.

Top module: `tlu_core`

## Requirements
- R1: Result bit i before masking equals fn_code[{op_a[i], op_b[i], op_c[i]}], where op_a is the most significant index bit. For example, code 0x96 gives a three-way XOR, 0xE8 gives majority, 0xF0 returns op_a, and 0x00 and 0xFF give constant zero and constant one.
- R2: When the mask bit of an element is 1, that element of the result equals the function output.
- R3: When the mask bit of an element is 0 and merge_en is 0, that element of the result is all zeros.
- R4: When the mask bit of an element is 0 and merge_en is 1, that element of the result equals the same element of pass_src.
- R5: When elem_64 is 1, element N covers bits 64N+63 down to 64N and is controlled by mask bit N, for N from 0 to 7. Mask bits 8 to 15 have no effect.
- R6: When elem_64 is 0, element N covers bits 32N+31 down to 32N and is controlled by mask bit N, for N from 0 to 15.
- R7: After reset, res_valid is 0 and op_ready is 1.
- R8: A result is presented on res_valid and res_data in the cycle after its operation is accepted. The result stays unchanged while res_valid is 1 and res_ready is 0.
- R9: op_ready is 1 exactly when the output register is empty or is being drained in that cycle. Results leave in the order in which operations were accepted, and operations can be accepted back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Unit can accept an operation |
| op_a | input | 512 | First operand (most significant truth-table index) |
| op_b | input | 512 | Second operand |
| op_c | input | 512 | Third operand (least significant index) |
| pass_src | input | 512 | Merge source for elements that are not selected |
| fn_code | input | 8 | Truth table of the three-input function |
| elem_mask | input | 16 | Per-element write mask |
| elem_64 | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| merge_en | input | 1 | 1: merge from pass_src, 0: zero unselected elements |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 512 | Masked result |

## Verification
The operands are first set to repeating bytes 0xF0, 0xCC and 0xAA, so that every bit byte walks through all eight truth-table rows. The masked-off result must then repeat the function code itself, which separates errors in index order from errors in the function. Random operands with the named codes (XOR, majority, pass, constants) and with random codes check the bitwise function across the whole width. Masks of all ones, all zeros, alternating bits and random values are run in both element widths and both modes. They separate zeroing from merging, and they show any mix-up between 32-bit and 64-bit element mapping, including whether the upper mask bits are ignored in 64-bit mode. Periods of random output stalls check that results are held, that ordering is kept and that back-to-back acceptance works.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  parameter int VEC_W   = 512;
  parameter int LANE_W  = 32;
  parameter int CODE_W  = 8;
  localparam int NUM_LANES = VEC_W / LANE_W;
  localparam int MASK_W    = NUM_LANES;

  typedef enum logic {
    FILL_ZERO  = 1'b0,
    FILL_MERGE = 1'b1
  } fill_mode_e;
endpackage

// File: rtl/tlu_bitfunc.sv
module tlu_bitfunc #(
  parameter int W = 512
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [7:0]   code,
  output logic [W-1:0] y
);
  // each bit position indexes the truth table with {a,b,c}
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = code[{a[i], b[i], c[i]}];
  end
endmodule

// File: rtl/tlu_lane_enable.sv
module tlu_lane_enable #(
  parameter int LANES = 16
) (
  input  logic [LANES-1:0] mask,
  input  logic             wide,
  output logic [LANES-1:0] en
);
  // a 64-bit element spans two adjacent 32-bit lanes sharing one mask bit
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int PAIR = j / 2;
    assign en[j] = wide ? mask[PAIR] : mask[j];
  end
endmodule

// File: rtl/tlu_lane_select.sv
module tlu_lane_select #(
  parameter int LANES  = 16,
  parameter int LANE_W = 32
) (
  input  logic [LANES*LANE_W-1:0] func,
  input  logic [LANES*LANE_W-1:0] src,
  input  logic [LANES-1:0]        en,
  input  logic                    merge,
  output logic [LANES*LANE_W-1:0] y
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] fill;
    assign fill = merge ? src[j*LANE_W +: LANE_W] : '0;
    assign y[j*LANE_W +: LANE_W] = en[j] ? func[j*LANE_W +: LANE_W] : fill;
  end
endmodule

// File: rtl/tlu_core.sv
module tlu_core
  import tlu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [VEC_W-1:0]  op_a,
  input  logic [VEC_W-1:0]  op_b,
  input  logic [VEC_W-1:0]  op_c,
  input  logic [VEC_W-1:0]  pass_src,
  input  logic [CODE_W-1:0] fn_code,
  input  logic [MASK_W-1:0] elem_mask,
  input  logic              elem_64,
  input  logic              merge_en,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [VEC_W-1:0]  res_data
);
  logic [VEC_W-1:0]     func_out;
  logic [VEC_W-1:0]     sel_out;
  logic [NUM_LANES-1:0] lane_en;
  logic                 vld_q, vld_d;
  logic [VEC_W-1:0]     data_q;
  logic                 accept;
  fill_mode_e           fill_mode;

  assign fill_mode = fill_mode_e'(merge_en);

  tlu_bitfunc #(.W(VEC_W)) u_func (
    .a(op_a), .b(op_b), .c(op_c), .code(fn_code), .y(func_out)
  );

  tlu_lane_enable #(.LANES(NUM_LANES)) u_en (
    .mask(elem_mask), .wide(elem_64), .en(lane_en)
  );

  tlu_lane_select #(.LANES(NUM_LANES), .LANE_W(LANE_W)) u_sel (
    .func(func_out), .src(pass_src), .en(lane_en),
    .merge(fill_mode == FILL_MERGE), .y(sel_out)
  );

  // handshake next state
  always_comb begin
    op_ready = !vld_q || res_ready;
    accept   = op_valid && op_ready;
    vld_d    = vld_q;
    if (accept)         vld_d = 1'b1;
    else if (res_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // data register with explicit load enable
  always_ff @(posedge clk) begin
    if (accept) data_q <= sel_out;
  end

  assign res_valid = vld_q;
  assign res_data  = data_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !op_ready) |=> $stable(res_data));

  assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lane_en[0]) |=> (res_data[LANE_W-1:0] == $past(func_out[LANE_W-1:0])));

  assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !lane_en[0] && !merge_en) |=> (res_data[LANE_W-1:0] == '0));

  assert_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !lane_en[NUM_LANES-1] && merge_en) |=>
    (res_data[VEC_W-1 -: LANE_W] == $past(pass_src[VEC_W-1 -: LANE_W])));
endmodule

// File: tb/sim_tlu_core.sv
module sim_tlu_core;
  import tlu_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              op_valid = 1'b0;
  logic              op_ready;
  logic [VEC_W-1:0]  op_a = '0, op_b = '0, op_c = '0, pass_src = '0;
  logic [CODE_W-1:0] fn_code = '0;
  logic [MASK_W-1:0] elem_mask = '0;
  logic              elem_64 = 1'b0, merge_en = 1'b0;
  logic              res_valid;
  logic              res_ready = 1'b1;
  logic [VEC_W-1:0]  res_data;

  int total = 0;
  int bad = 0;
  int stall_mode = 0;
  logic [VEC_W-1:0] exp_q[$];
  string            tag_q[$];

  always #5 clk = ~clk;

  tlu_core u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .pass_src(pass_src),
    .fn_code(fn_code), .elem_mask(elem_mask), .elem_64(elem_64),
    .merge_en(merge_en), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data)
  );

  task automatic check(input bit ok, input string req, input logic [VEC_W-1:0] act,
                       input logic [VEC_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VEC_W-1:0] model(
    input logic [VEC_W-1:0] a, b, c, s, input logic [7:0] code,
    input logic [MASK_W-1:0] m, input logic wide, input logic mrg);
    logic [VEC_W-1:0] r;
    for (int i = 0; i < VEC_W; i++) r[i] = code[{a[i], b[i], c[i]}];
    for (int j = 0; j < NUM_LANES; j++) begin
      logic en;
      en = wide ? m[j/2] : m[j];
      if (!en) r[j*LANE_W +: LANE_W] = mrg ? s[j*LANE_W +: LANE_W] : '0;
    end
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] rnd_vec();
    logic [VEC_W-1:0] v;
    for (int k = 0; k < VEC_W/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // driver: pushes expected items, then completes the handshake
  task automatic issue(input logic [VEC_W-1:0] a, b, c, s, input logic [7:0] code,
                       input logic [MASK_W-1:0] m, input logic wide, input logic mrg,
                       input string tag);
    @(negedge clk);
    op_a = a; op_b = b; op_c = c; pass_src = s; fn_code = code;
    elem_mask = m; elem_64 = wide; merge_en = mrg; op_valid = 1'b1;
    #4;
    while (!op_ready) begin
      @(negedge clk);
      #4;
    end
    exp_q.push_back(model(a, b, c, s, code, m, wide, mrg));
    tag_q.push_back(tag);
    @(posedge clk);
    #2;
    check(res_valid == 1'b1, "R8 latency", {511'd0, res_valid}, {511'd0, 1'b1});
    op_valid = 1'b0;
  endtask

  // monitor: chooses res_ready, then compares any result leaving this cycle
  initial begin : monitor
    logic [VEC_W-1:0] held;
    bit was_stalled;
    was_stalled = 0;
    held = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (was_stalled)
          check(res_valid && res_data == held, "R8 hold", res_data, held);
        res_ready = (stall_mode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
        #1;
        check(op_ready == (!res_valid || res_ready), "R9 ready",
              {511'd0, op_ready}, {511'd0, (!res_valid || res_ready)});
        if (res_valid && res_ready) begin
          if (exp_q.size() == 0) check(1'b0, "R9 order (extra result)", res_data, '0);
          else begin
            logic [VEC_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(res_data == e, t, res_data, e);
          end
        end
        was_stalled = res_valid && !res_ready;
        held = res_data;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    logic [VEC_W-1:0] pa, pb, pc;
    logic [7:0] named [5];
    named = '{8'h96, 8'hE8, 8'hF0, 8'h00, 8'hFF};
    pa = {64{8'hF0}}; pb = {64{8'hCC}}; pc = {64{8'hAA}};
    repeat (3) @(posedge clk);
    #1;
    check(res_valid == 1'b0 && op_ready == 1'b1, "R7 reset",
          {510'd0, res_valid, op_ready}, {510'd0, 2'b01});
    @(negedge clk);
    rst_n = 1'b1;

    // R1: truth-table walk, result repeats the code
    issue(pa, pb, pc, '0, 8'h96, 16'hFFFF, 1'b0, 1'b0, "R1 walk 96");
    issue(pa, pb, pc, '0, 8'hE8, 16'hFFFF, 1'b1, 1'b0, "R1 walk E8");
    issue(pa, pb, pc, '0, 8'h1B, 16'hFFFF, 1'b0, 1'b1, "R1 walk 1B");
    // R1 named codes on random data, all lanes written (R2)
    for (int n = 0; n < 5; n++)
      issue(rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), named[n], 16'hFFFF,
            n[0], 1'b1, "R1 R2 named code");
    // R3 zeroing and R4 merging with all mask bits clear
    issue(rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), 8'hFF, 16'h0000, 1'b0, 1'b0, "R3 all zero");
    issue(rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), 8'hFF, 16'h0000, 1'b1, 1'b1, "R4 all merge");
    // R6 narrow elements, alternating masks
    issue(rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), 8'hE8, 16'h5555, 1'b0, 1'b1, "R6 narrow 5555");
    issue(rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), 8'h96, 16'hA5C3, 1'b0, 1'b0, "R6 narrow A5C3");
    // R5 wide elements, upper mask bits must be ignored
    issue(rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), 8'hFF, 16'hFF00, 1'b1, 1'b0, "R5 upper ignored");
    issue(rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), 8'hF0, 16'h0055, 1'b1, 1'b1, "R5 wide 55");
    issue(rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), 8'h96, 16'hAA81, 1'b1, 1'b0, "R5 wide 81");
    // random mix with output stalls: R8 hold, R9 order/back-to-back
    stall_mode = 1;
    for (int n = 0; n < 40; n++)
      issue(rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), 8'($urandom),
            16'($urandom), 1'($urandom), 1'($urandom), "R9 R2 random stalled");
    stall_mode = 0;
    for (int n = 0; n < 60 && exp_q.size() != 0; n++) @(posedge clk);
    check(exp_q.size() == 0, "R9 all results drained", {480'd0, 32'(exp_q.size())}, '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule